// File: doc/BRIEF.md
# Bank-Group Command Spacing Monitor

This block watches the command stream a memory controller sends to a DRAM device that divides its banks into bank groups. It does not change or delay any command; it measures, in clock cycles, how far each new command lies from earlier commands. It flags the command when that distance is below a programmed minimum. Three spacing rules are watched: row activation to row activation, column access to column access (reads and writes both count as column accesses), and write to a later read. Each rule has two limits. The longer one applies when the earlier command went to the same bank group, and the shorter one applies when it went to another group.

For every bank group and every rule, the monitor keeps a saturating counter of the cycles since that group last saw the rule's source command. A new command compares the counter of its own group with the long limit and the counters of all other active groups with the short limit. A mode input chooses between four groups, where the full group field is used, and two groups, where only the low bit of the field is used. Violations come out as one-cycle pulses, one per rule, in the cycle after the offending command. They also set sticky status bits that stay set until a clear input is raised.

Top module: `bgchk_top`

## Requirements
- R1: After reset all violation pulses and sticky bits are 0, and the first command after reset never raises a violation.
- R2: An ACTIVATE (cmd code 2'b01) issued d cycles after an ACTIVATE to the same bank group raises `viol_rrd` in the following cycle exactly when d < `lim_rrd_l`.
- R3: An ACTIVATE issued d cycles after an ACTIVATE to a different bank group raises `viol_rrd` exactly when d < `lim_rrd_s`.
- R4: A column command (READ 2'b10 or WRITE 2'b11) issued d cycles after any column command raises `viol_ccd` exactly when d < `lim_ccd_l` for the same group, or d < the effective short limit for a different group.
- R5: The effective short column limit is the larger of `lim_ccd_s` and 4, so a programmed value below 4 acts as 4.
- R6: A READ issued d cycles after a WRITE raises `viol_wtr` exactly when d < `lim_wtr_l` for the same group, or d < `lim_wtr_s` for a different group. No other command pair raises `viol_wtr`.
- R7: Each pulse sets its sticky bit (`viol_sticky[0]` rrd, `[1]` ccd, `[2]` wtr). The bit holds until `sticky_clr` is high at a clock edge, and a new violation at that same edge keeps it set.
- R8: With `two_grp_mode` = 1, only bit 0 of `bg` selects the group, so groups 0 and 2 count as the same group and groups 1 and 2 count as different groups.
- R9: Cycle counters saturate at 2^CNT_W-1 (63 by default), so after a long idle period no violation is raised, even with a limit of 62 or 63.
- R10: A NOP (cmd code 2'b00) raises no violation and counts as no event for any rule.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd | input | 2 | Command code: 00 NOP, 01 ACTIVATE, 10 READ, 11 WRITE |
| bg | input | BG_W | Bank group of the command |
| two_grp_mode | input | 1 | 1: two groups, only bg[0] used; 0: all groups |
| lim_rrd_s | input | CNT_W | Activate spacing, different group |
| lim_rrd_l | input | CNT_W | Activate spacing, same group |
| lim_ccd_s | input | CNT_W | Column spacing, different group (floor 4) |
| lim_ccd_l | input | CNT_W | Column spacing, same group |
| lim_wtr_s | input | CNT_W | Write-to-read spacing, different group |
| lim_wtr_l | input | CNT_W | Write-to-read spacing, same group |
| sticky_clr | input | 1 | Clears the sticky bits |
| viol_rrd | output | 1 | One-cycle activate-spacing violation pulse |
| viol_ccd | output | 1 | One-cycle column-spacing violation pulse |
| viol_wtr | output | 1 | One-cycle write-to-read violation pulse |
| viol_sticky | output | 3 | Sticky violation flags {wtr, ccd, rrd} |

## Verification
The bench sends pairs of commands: activate/activate, read/read, write/read, read/write, write/write and activate/read. Every distance from 1 to 8 cycles is tried, for both same-group and different-group pairs, in both group modes. It then compares each rule's pulse with the limit inequality. This separates the same-group long limit from the different-group short limit and shows which command pairs feed which rule. Separate runs cover the short column floor, counter saturation with limits near the counter maximum, NOP commands as either member of a pair, and a clear that lands on the same edge as a new violation.

// File: rtl/bgchk_pkg.sv
package bgchk_pkg;
    typedef enum logic [1:0] {
        CMD_NOP = 2'b00,
        CMD_ACT = 2'b01,
        CMD_RD  = 2'b10,
        CMD_WR  = 2'b11
    } bg_cmd_e;

    localparam int RULE_RRD  = 0;
    localparam int RULE_CCD  = 1;
    localparam int RULE_WTR  = 2;
    localparam int NUM_RULES = 3;
endpackage

// File: rtl/bgchk_age.sv
// Per-group saturating "cycles since last event" counters.
module bgchk_age #(
    parameter int BG_W   = 2,
    parameter int CNT_W  = 6,
    parameter int NUM_BG = 1 << BG_W
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           hit,
    input  logic [BG_W-1:0]                grp,
    output logic [NUM_BG-1:0][CNT_W-1:0]   age
);
    localparam logic [CNT_W-1:0] AGE_MAX = '1;

    for (genvar g = 0; g < NUM_BG; g++) begin : g_grp
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                age[g] <= AGE_MAX;
            end else if (hit && (grp == BG_W'(g))) begin
                age[g] <= CNT_W'(1);
            end else if (age[g] != AGE_MAX) begin
                age[g] <= age[g] + CNT_W'(1);
            end
        end
    end
endmodule

// File: rtl/bgchk_rule.sv
// Compares ages against the same-group and other-group limits.
module bgchk_rule #(
    parameter int BG_W   = 2,
    parameter int CNT_W  = 6,
    parameter int NUM_BG = 1 << BG_W
) (
    input  logic                           fire,
    input  logic [BG_W-1:0]                grp,
    input  logic [NUM_BG-1:0]              grp_mask,
    input  logic [NUM_BG-1:0][CNT_W-1:0]   age,
    input  logic [CNT_W-1:0]               lim_same,
    input  logic [CNT_W-1:0]               lim_other,
    output logic                           viol
);
    logic near;

    always_comb begin
        near = 1'b0;
        for (int g = 0; g < NUM_BG; g++) begin
            if (grp == BG_W'(g)) begin
                if (age[g] < lim_same) near = 1'b1;
            end else if (grp_mask[g]) begin
                if (age[g] < lim_other) near = 1'b1;
            end
        end
        viol = fire && near;
    end
endmodule

// File: rtl/bgchk_top.sv
module bgchk_top #(
    parameter int BG_W      = 2,
    parameter int CNT_W     = 6,
    parameter int CCD_S_MIN = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        cmd,
    input  logic [BG_W-1:0]   bg,
    input  logic              two_grp_mode,
    input  logic [CNT_W-1:0]  lim_rrd_s,
    input  logic [CNT_W-1:0]  lim_rrd_l,
    input  logic [CNT_W-1:0]  lim_ccd_s,
    input  logic [CNT_W-1:0]  lim_ccd_l,
    input  logic [CNT_W-1:0]  lim_wtr_s,
    input  logic [CNT_W-1:0]  lim_wtr_l,
    input  logic              sticky_clr,
    output logic              viol_rrd,
    output logic              viol_ccd,
    output logic              viol_wtr,
    output logic [2:0]        viol_sticky
);
    import bgchk_pkg::*;

    localparam int              NUM_BG    = 1 << BG_W;
    localparam logic [CNT_W-1:0] CCD_FLOOR = CNT_W'(CCD_S_MIN);

    bg_cmd_e                       cmd_e;
    logic                          is_act, is_col, is_wr, is_rd;
    logic [BG_W-1:0]               grp;
    logic [NUM_BG-1:0]             grp_mask;
    logic [CNT_W-1:0]              ccd_s_eff;
    logic [NUM_BG-1:0][CNT_W-1:0]  age_act, age_col, age_wr;
    logic [NUM_RULES-1:0]          viol_c;

    // Command decode
    always_comb begin
        cmd_e  = bg_cmd_e'(cmd);
        is_act = 1'b0;
        is_col = 1'b0;
        is_wr  = 1'b0;
        is_rd  = 1'b0;
        unique case (cmd_e)
            CMD_NOP: ;
            CMD_ACT: is_act = 1'b1;
            CMD_RD:  begin is_col = 1'b1; is_rd = 1'b1; end
            CMD_WR:  begin is_col = 1'b1; is_wr = 1'b1; end
        endcase
    end

    // Group interpretation by width mode
    always_comb begin
        grp = two_grp_mode ? (bg & BG_W'(1)) : bg;
        for (int g = 0; g < NUM_BG; g++) begin
            grp_mask[g] = !two_grp_mode || (g < 2);
        end
        ccd_s_eff = (lim_ccd_s < CCD_FLOOR) ? CCD_FLOOR : lim_ccd_s;
    end

    bgchk_age #(.BG_W(BG_W), .CNT_W(CNT_W), .NUM_BG(NUM_BG)) u_age_act (
        .clk(clk), .rst_n(rst_n), .hit(is_act), .grp(grp), .age(age_act));
    bgchk_age #(.BG_W(BG_W), .CNT_W(CNT_W), .NUM_BG(NUM_BG)) u_age_col (
        .clk(clk), .rst_n(rst_n), .hit(is_col), .grp(grp), .age(age_col));
    bgchk_age #(.BG_W(BG_W), .CNT_W(CNT_W), .NUM_BG(NUM_BG)) u_age_wr (
        .clk(clk), .rst_n(rst_n), .hit(is_wr), .grp(grp), .age(age_wr));

    bgchk_rule #(.BG_W(BG_W), .CNT_W(CNT_W), .NUM_BG(NUM_BG)) u_rule_rrd (
        .fire(is_act), .grp(grp), .grp_mask(grp_mask), .age(age_act),
        .lim_same(lim_rrd_l), .lim_other(lim_rrd_s), .viol(viol_c[RULE_RRD]));
    bgchk_rule #(.BG_W(BG_W), .CNT_W(CNT_W), .NUM_BG(NUM_BG)) u_rule_ccd (
        .fire(is_col), .grp(grp), .grp_mask(grp_mask), .age(age_col),
        .lim_same(lim_ccd_l), .lim_other(ccd_s_eff), .viol(viol_c[RULE_CCD]));
    bgchk_rule #(.BG_W(BG_W), .CNT_W(CNT_W), .NUM_BG(NUM_BG)) u_rule_wtr (
        .fire(is_rd), .grp(grp), .grp_mask(grp_mask), .age(age_wr),
        .lim_same(lim_wtr_l), .lim_other(lim_wtr_s), .viol(viol_c[RULE_WTR]));

    // Registered pulses and sticky status
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            viol_rrd    <= 1'b0;
            viol_ccd    <= 1'b0;
            viol_wtr    <= 1'b0;
            viol_sticky <= '0;
        end else begin
            viol_rrd    <= viol_c[RULE_RRD];
            viol_ccd    <= viol_c[RULE_CCD];
            viol_wtr    <= viol_c[RULE_WTR];
            viol_sticky <= (viol_sticky & ~{3{sticky_clr}}) | viol_c;
        end
    end
endmodule

// File: rtl/bgchk_sva.sv
module bgchk_sva #(
    parameter int BG_W  = 2,
    parameter int CNT_W = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic [1:0]        cmd,
    input logic [BG_W-1:0]   bg,
    input logic              two_grp_mode,
    input logic              sticky_clr,
    input logic              viol_rrd,
    input logic              viol_ccd,
    input logic              viol_wtr,
    input logic [2:0]        viol_sticky
);
    // R10: a NOP produces no pulse
    a_r10_nop_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        cmd == 2'b00 |=> !viol_rrd && !viol_ccd && !viol_wtr);

    // R2: only an ACTIVATE can raise the activate rule
    a_r2_rrd_only_act: assert property (@(posedge clk) disable iff (!rst_n)
        cmd != 2'b01 |=> !viol_rrd);

    // R4: only column commands raise the column rule
    a_r4_ccd_only_col: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd[1] |=> !viol_ccd);

    // R6: only a READ raises the write-to-read rule
    a_r6_wtr_only_read: assert property (@(posedge clk) disable iff (!rst_n)
        cmd != 2'b10 |=> !viol_wtr);

    // R5: back-to-back column commands to different groups always violate
    a_r5_floor_back_to_back: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd[1] && !two_grp_mode) ##1 (cmd[1] && !two_grp_mode && bg != $past(bg))
        |=> viol_ccd);

    // R7: pulses set sticky, sticky holds without clear
    a_r7_pulse_sets_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (viol_rrd |-> viol_sticky[0]) and (viol_ccd |-> viol_sticky[1])
        and (viol_wtr |-> viol_sticky[2]));

    a_r7_sticky_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (viol_sticky[0] && !sticky_clr) |=> viol_sticky[0]);
endmodule

bind bgchk_top bgchk_sva #(.BG_W(BG_W), .CNT_W(CNT_W)) u_sva (
    .clk(clk), .rst_n(rst_n), .cmd(cmd), .bg(bg), .two_grp_mode(two_grp_mode),
    .sticky_clr(sticky_clr), .viol_rrd(viol_rrd), .viol_ccd(viol_ccd),
    .viol_wtr(viol_wtr), .viol_sticky(viol_sticky));

// File: tb/tb_bgchk_top.sv
module tb_bgchk_top;
    localparam int BG_W  = 2;
    localparam int CNT_W = 6;
    localparam logic [1:0] NOP = 2'b00, ACT = 2'b01, RD = 2'b10, WR = 2'b11;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [1:0]       cmd = NOP;
    logic [BG_W-1:0]  bg = '0;
    logic             two_grp_mode = 1'b0;
    logic [CNT_W-1:0] lim_rrd_s, lim_rrd_l, lim_ccd_s, lim_ccd_l, lim_wtr_s, lim_wtr_l;
    logic             sticky_clr = 1'b0;
    logic             viol_rrd, viol_ccd, viol_wtr;
    logic [2:0]       viol_sticky;

    int errs = 0;
    int checks = 0;
    bit done = 0;

    always #5 clk = ~clk;

    bgchk_top #(.BG_W(BG_W), .CNT_W(CNT_W)) dut (
        .clk(clk), .rst_n(rst_n), .cmd(cmd), .bg(bg), .two_grp_mode(two_grp_mode),
        .lim_rrd_s(lim_rrd_s), .lim_rrd_l(lim_rrd_l), .lim_ccd_s(lim_ccd_s),
        .lim_ccd_l(lim_ccd_l), .lim_wtr_s(lim_wtr_s), .lim_wtr_l(lim_wtr_l),
        .sticky_clr(sticky_clr), .viol_rrd(viol_rrd), .viol_ccd(viol_ccd),
        .viol_wtr(viol_wtr), .viol_sticky(viol_sticky));

    task automatic chk(input int got, input int exp, input string tag);
        checks++;
        if (got != exp) begin
            errs++;
            $display("FAIL %s: got %0d expected %0d", tag, got, exp);
        end
    endtask

    task automatic idle(input int n);
        cmd = NOP;
        repeat (n) @(negedge clk);
    endtask

    // Called just after a negedge. Issues a, then b d cycles later, checks.
    task automatic trial(input logic [1:0] a, input logic [1:0] ga, input int d,
                         input logic [1:0] b, input logic [1:0] gb,
                         input logic mode, input string over);
        bit same, er, ec, ew;
        int ccd_short;
        string tr, tc, tw;
        two_grp_mode = mode;
        idle(70);
        cmd = a; bg = ga;
        @(negedge clk);
        cmd = NOP;
        repeat (d - 1) @(negedge clk);
        cmd = b; bg = gb;
        @(negedge clk);
        cmd = NOP;
        same = mode ? (ga[0] == gb[0]) : (ga == gb);
        ccd_short = (int'(lim_ccd_s) < 4) ? 4 : int'(lim_ccd_s);
        er = (a == ACT) && (b == ACT) && (d < (same ? int'(lim_rrd_l) : int'(lim_rrd_s)));
        ec = a[1] && b[1] && (d < (same ? int'(lim_ccd_l) : ccd_short));
        ew = (a == WR) && (b == RD) && (d < (same ? int'(lim_wtr_l) : int'(lim_wtr_s)));
        tr = mode ? "R8" : (same ? "R2" : "R3");
        tc = mode ? "R8" : "R4";
        tw = mode ? "R8" : "R6";
        if (over != "") begin tr = over; tc = over; tw = over; end
        chk(int'(viol_rrd), int'(er), tr);
        chk(int'(viol_ccd), int'(ec), tc);
        chk(int'(viol_wtr), int'(ew), tw);
        chk(int'(viol_sticky), int'({ew, ec, er}), "R7 sticky");
        sticky_clr = 1'b1;
        @(negedge clk);
        sticky_clr = 1'b0;
        if (er || ec || ew) chk(int'(viol_sticky), 0, "R7 cleared");
    endtask

    initial begin
        logic [1:0] pa [6];
        logic [1:0] pb [6];
        pa = '{ACT, RD, WR, RD, WR, ACT};
        pb = '{ACT, RD, RD, WR, WR, RD};
        lim_rrd_s = 6'd2; lim_rrd_l = 6'd5;
        lim_ccd_s = 6'd4; lim_ccd_l = 6'd6;
        lim_wtr_s = 6'd3; lim_wtr_l = 6'd7;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        chk(int'({viol_rrd, viol_ccd, viol_wtr}), 0, "R1 reset pulses");
        chk(int'(viol_sticky), 0, "R1 reset sticky");
        // R1: first commands after reset
        cmd = ACT; bg = 2'd0;
        @(negedge clk);
        cmd = WR; bg = 2'd1;
        @(negedge clk);
        cmd = NOP;
        chk(int'(viol_rrd), 0, "R1 first act");
        @(negedge clk);
        chk(int'(viol_ccd), 0, "R1 first column");

        // Main sweep in both modes
        for (int m = 0; m < 2; m++) begin
            for (int p = 0; p < 6; p++) begin
                for (int d = 1; d <= 8; d++) begin
                    if (m == 0) begin
                        trial(pa[p], 2'd1, d, pb[p], 2'd1, 1'b0, "");
                        trial(pa[p], 2'd1, d, pb[p], 2'd2, 1'b0, "");
                    end else begin
                        trial(pa[p], 2'd0, d, pb[p], 2'd2, 1'b1, "");
                        trial(pa[p], 2'd1, d, pb[p], 2'd2, 1'b1, "");
                    end
                end
            end
        end

        // R5: short column limit below the floor
        lim_ccd_s = 6'd1;
        for (int d = 1; d <= 6; d++) begin
            trial(RD, 2'd0, d, WR, 2'd3, 1'b0, "R5");
        end
        lim_ccd_s = 6'd4;

        // R9: saturation with limits near the counter maximum
        lim_rrd_l = 6'd63;
        trial(ACT, 2'd3, 62, ACT, 2'd3, 1'b0, "R9");
        trial(ACT, 2'd3, 80, ACT, 2'd3, 1'b0, "R9");
        lim_wtr_s = 6'd62;
        trial(WR, 2'd0, 61, RD, 2'd1, 1'b0, "R9");
        trial(WR, 2'd0, 90, RD, 2'd1, 1'b0, "R9");
        lim_rrd_l = 6'd5; lim_wtr_s = 6'd3;

        // R10: NOP as either member of a pair
        for (int d = 1; d <= 3; d++) begin
            trial(NOP, 2'd2, d, ACT, 2'd2, 1'b0, "R10");
            trial(WR, 2'd2, d, NOP, 2'd2, 1'b0, "R10");
        end

        // R7: clear on the same edge as a new violation keeps the bit set
        idle(70);
        cmd = ACT; bg = 2'd3;
        @(negedge clk);
        cmd = ACT; bg = 2'd3; sticky_clr = 1'b1;
        @(negedge clk);
        cmd = NOP; sticky_clr = 1'b0;
        chk(int'(viol_sticky[0]), 1, "R7 set wins over clear");
        idle(5);
        chk(int'(viol_sticky[0]), 1, "R7 held");
        sticky_clr = 1'b1;
        @(negedge clk);
        sticky_clr = 1'b0;
        chk(int'(viol_sticky), 0, "R7 clear");

        done = 1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errs++;
            checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end
endmodule